// File: doc/BRIEF.md
# Vectored Fast/Normal Interrupt Controller

This block gathers 32 level interrupt sources, synchronous to its clock, and merges them with a software-settable request register. Each source is steered by a per-source select bit to one of two processor request lines. One line is the fast request and the other is the normal request. Enable bits and software-request bits are each changed through a pair of write-1 registers, one to set and one to clear. This lets software change single bits without a read-modify-write.

For the normal line, sixteen vector slots each hold a source number, a slot-enable bit and a 32-bit handler address. The block continuously presents the handler address of the lowest-numbered enabled slot whose source is currently requesting on the normal line. When no slot matches, it presents a programmable default address. All status, configuration and the current vector can be read back through a simple single-cycle register port. Writes take effect at the clock edge. Reads and both request outputs are combinational.

Top module: `intc_vic`

## Requirements
- R1: Raw status (misc register 0) is the bitwise OR of `src_i` and the software-request bits. It is unaffected by enable and select.
- R2: With select register (misc 3) bit n = 1, source n contributes to fast status (misc 1 = raw & enable & select). With the bit = 0, it contributes to normal status (misc 2 = raw & enable & ~select).
- R3: A write to enable-set (misc 4) sets every enable bit whose data bit is 1. A write to enable-clear (misc 5) clears them. Data bits of 0 leave the enable bit unchanged. Reading misc 4 or misc 5 returns the enable bits.
- R4: Software-request bits follow the same write-1 rule, with set at misc 6 and clear at misc 7. Reading either address returns the bits.
- R5: `fiq_o` is the OR of fast status and `irq_o` is the OR of normal status, both without a cycle of delay.
- R6: The address is 6 bits. Bits [5:4] select the region: 0 = misc registers, 1 = slot control, 2 = slot address. Bits [3:0] give the register or slot index. Slot control holds the source number in bits [4:0] and the slot enable in bit 5, and reads back in the same layout. Slot address holds 32 bits.
- R7: `vec_addr_o` (also readable at misc 8) is the address of the lowest-index enabled slot whose source has its normal-status bit set.
- R8: When no enabled slot matches, `vec_addr_o` equals the default address register (misc 9).
- R9: After reset, enables, selects, software requests, slot enables and the default address are zero. Both request outputs are therefore low.
- R10: A source routed to the fast line, or a slot with its enable at 0, never selects the vector, even when the slot's source number matches an active source.
- R11: Unused addresses read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt sources |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| vec_addr_o | output | 32 | Handler address of the winning normal source |

## Verification
The bench builds the block with its defaults: 32 sources, 16 slots and 32-bit data. This gives full coverage of every source number in the 5-bit slot field and of all sixteen priority positions. Random programming of many slots with overlapping source numbers brings ties within reach, where several slots name active sources and only the lowest index may win. Directed cases cover a matching slot that is disabled, a matching source routed to the fast line, and the fall-back to the default address.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [3:0] {
    REG_RAW      = 4'd0,
    REG_FAST     = 4'd1,
    REG_NORM     = 4'd2,
    REG_SEL      = 4'd3,
    REG_EN_SET   = 4'd4,
    REG_EN_CLR   = 4'd5,
    REG_SOFT_SET = 4'd6,
    REG_SOFT_CLR = 4'd7,
    REG_VEC      = 4'd8,
    REG_DFLT     = 4'd9
  } misc_reg_e;

  typedef enum logic [1:0] {
    RGN_MISC     = 2'd0,
    RGN_SLOT_CTL = 2'd1,
    RGN_SLOT_ADR = 2'd2,
    RGN_NONE     = 2'd3
  } region_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DATA_W = 32,
  parameter int LO_W   = 4,
  parameter int IDX_W  = 5,
  localparam int ADDR_W = LO_W + 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [N_SRC-1:0]                  sel_q_o,
  output logic [N_SRC-1:0]                  en_q_o,
  output logic [N_SRC-1:0]                  soft_q_o,
  output logic [DATA_W-1:0]                 dflt_q_o,
  output logic [N_SLOT-1:0]                 slot_en_q_o,
  output logic [N_SLOT-1:0][IDX_W-1:0]      slot_src_q_o,
  output logic [N_SLOT-1:0][DATA_W-1:0]     slot_adr_q_o
);
  logic [1:0]      rgn;
  logic [LO_W-1:0] lo;
  logic            misc_we;
  logic [N_SRC-1:0] wbits;

  assign rgn     = addr_i[ADDR_W-1 -: 2];
  assign lo      = addr_i[LO_W-1:0];
  assign misc_we = we_i && (rgn == RGN_MISC);
  assign wbits   = wdata_i[N_SRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q_o  <= '0;
      en_q_o   <= '0;
      soft_q_o <= '0;
      dflt_q_o <= '0;
    end else if (misc_we) begin
      if (lo == LO_W'(REG_SEL))      sel_q_o  <= wbits;
      if (lo == LO_W'(REG_EN_SET))   en_q_o   <= en_q_o | wbits;
      if (lo == LO_W'(REG_EN_CLR))   en_q_o   <= en_q_o & ~wbits;
      if (lo == LO_W'(REG_SOFT_SET)) soft_q_o <= soft_q_o | wbits;
      if (lo == LO_W'(REG_SOFT_CLR)) soft_q_o <= soft_q_o & ~wbits;
      if (lo == LO_W'(REG_DFLT))     dflt_q_o <= wdata_i;
    end
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    logic hit;
    assign hit = (lo == LO_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_en_q_o[s]  <= 1'b0;
        slot_src_q_o[s] <= '0;
        slot_adr_q_o[s] <= '0;
      end else if (we_i && hit) begin
        if (rgn == RGN_SLOT_CTL) begin
          slot_src_q_o[s] <= wdata_i[IDX_W-1:0];
          slot_en_q_o[s]  <= wdata_i[IDX_W];
        end
        if (rgn == RGN_SLOT_ADR) slot_adr_q_o[s] <= wdata_i;
      end
    end
  end

  logic en_wr, soft_wr;
  assign en_wr   = misc_we && (lo == LO_W'(REG_EN_SET) || lo == LO_W'(REG_EN_CLR));
  assign soft_wr = misc_we && (lo == LO_W'(REG_SOFT_SET) || lo == LO_W'(REG_SOFT_CLR));

  p_en_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misc_we && lo == LO_W'(REG_EN_SET)) |=>
      ((en_q_o & $past(wbits)) == $past(wbits)));
  p_en_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misc_we && lo == LO_W'(REG_EN_CLR)) |=> ((en_q_o & $past(wbits)) == '0));
  p_en_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr |=> $stable(en_q_o));
  p_soft_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misc_we && lo == LO_W'(REG_SOFT_SET)) |=>
      ((soft_q_o & $past(wbits)) == $past(wbits)));
  p_soft_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misc_we && lo == LO_W'(REG_SOFT_CLR)) |=> ((soft_q_o & $past(wbits)) == '0));
  p_soft_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_wr |=> $stable(soft_q_o));
endmodule

// File: rtl/intc_status.sv
module intc_status #(
  parameter int N_SRC = 32
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] soft_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] sel_i,
  output logic [N_SRC-1:0] raw_o,
  output logic [N_SRC-1:0] fast_o,
  output logic [N_SRC-1:0] norm_o,
  output logic             fiq_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] live;
  assign raw_o  = src_i | soft_i;
  assign live   = raw_o & en_i;
  assign fast_o = live & sel_i;
  assign norm_o = live & ~sel_i;
  assign fiq_o  = |fast_o;
  assign irq_o  = |norm_o;
endmodule

// File: rtl/intc_vec_pick.sv
module intc_vec_pick #(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [N_SRC-1:0]              norm_i,
  input  logic [N_SLOT-1:0]             slot_en_i,
  input  logic [N_SLOT-1:0][IDX_W-1:0]  slot_src_i,
  input  logic [N_SLOT-1:0][DATA_W-1:0] slot_adr_i,
  input  logic [DATA_W-1:0]             dflt_i,
  output logic [DATA_W-1:0]             vec_o,
  output logic                          hit_o
);
  logic [N_SLOT-1:0] match;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_match
    assign match[s] = slot_en_i[s] && norm_i[slot_src_i[s]];
  end

  // highest index first so the lowest matching slot is written last
  always_comb begin
    vec_o = dflt_i;
    for (int s = N_SLOT - 1; s >= 0; s--) begin
      if (match[s]) vec_o = slot_adr_i[s];
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/intc_vic.sv
module intc_vic
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int SLOT_W = $clog2(N_SLOT),
  localparam int LO_W   = (SLOT_W > 4) ? SLOT_W : 4,
  localparam int ADDR_W = LO_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              fiq_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] vec_addr_o
);
  logic [N_SRC-1:0]              sel_q, en_q, soft_q, raw, fast, norm;
  logic [DATA_W-1:0]             dflt_q;
  logic [N_SLOT-1:0]             slot_en_q;
  logic [N_SLOT-1:0][IDX_W-1:0]  slot_src_q;
  logic [N_SLOT-1:0][DATA_W-1:0] slot_adr_q;
  logic                          vec_hit;

  intc_regs #(
    .N_SRC(N_SRC), .N_SLOT(N_SLOT), .DATA_W(DATA_W), .LO_W(LO_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i         (bus_we_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .sel_q_o      (sel_q),
    .en_q_o       (en_q),
    .soft_q_o     (soft_q),
    .dflt_q_o     (dflt_q),
    .slot_en_q_o  (slot_en_q),
    .slot_src_q_o (slot_src_q),
    .slot_adr_q_o (slot_adr_q)
  );

  intc_status #(.N_SRC(N_SRC)) u_status (
    .src_i, .soft_i(soft_q), .en_i(en_q), .sel_i(sel_q),
    .raw_o(raw), .fast_o(fast), .norm_o(norm), .fiq_o, .irq_o
  );

  intc_vec_pick #(
    .N_SRC(N_SRC), .N_SLOT(N_SLOT), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_pick (
    .norm_i(norm), .slot_en_i(slot_en_q), .slot_src_i(slot_src_q),
    .slot_adr_i(slot_adr_q), .dflt_i(dflt_q), .vec_o(vec_addr_o), .hit_o(vec_hit)
  );

  logic [1:0]      rgn;
  logic [LO_W-1:0] lo;
  assign rgn = bus_addr_i[ADDR_W-1 -: 2];
  assign lo  = bus_addr_i[LO_W-1:0];

  always_comb begin
    bus_rdata_o = '0;
    unique case (rgn)
      RGN_MISC: begin
        case (lo)
          LO_W'(REG_RAW):      bus_rdata_o = DATA_W'(raw);
          LO_W'(REG_FAST):     bus_rdata_o = DATA_W'(fast);
          LO_W'(REG_NORM):     bus_rdata_o = DATA_W'(norm);
          LO_W'(REG_SEL):      bus_rdata_o = DATA_W'(sel_q);
          LO_W'(REG_EN_SET),
          LO_W'(REG_EN_CLR):   bus_rdata_o = DATA_W'(en_q);
          LO_W'(REG_SOFT_SET),
          LO_W'(REG_SOFT_CLR): bus_rdata_o = DATA_W'(soft_q);
          LO_W'(REG_VEC):      bus_rdata_o = vec_addr_o;
          LO_W'(REG_DFLT):     bus_rdata_o = dflt_q;
          default:             bus_rdata_o = '0;
        endcase
      end
      RGN_SLOT_CTL: begin
        for (int s = 0; s < N_SLOT; s++)
          if (lo == LO_W'(s)) bus_rdata_o = DATA_W'({slot_en_q[s], slot_src_q[s]});
      end
      RGN_SLOT_ADR: begin
        for (int s = 0; s < N_SLOT; s++)
          if (lo == LO_W'(s)) bus_rdata_o = slot_adr_q[s];
      end
      default: bus_rdata_o = '0;
    endcase
  end

  p_default_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_addr_o == dflt_q));
  p_hit_needs_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_hit |-> irq_o);
  p_fiq_needs_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> (|(sel_q & en_q)));
  p_irq_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(en_q & ~sel_q)));
endmodule

// File: tb/sim_intc_vic.sv
module sim_intc_vic;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32, NSL = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src = '0, wdata = '0, rdata, vec;
  logic        we = 1'b0, fiq, irq;
  logic [5:0]  addr = '0;
  int n_chk = 0, n_bad = 0;

  // bench model
  logic [31:0] m_sel, m_en, m_soft, m_dflt;
  logic [NSL-1:0] m_sen;
  logic [4:0]  m_ssrc [NSL];
  logic [31:0] m_sadr [NSL];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_vic u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq), .vec_addr_o(vec)
  );

  function automatic logic [31:0] e_raw();  return src | m_soft; endfunction
  function automatic logic [31:0] e_fast(); return e_raw() & m_en & m_sel; endfunction
  function automatic logic [31:0] e_norm(); return e_raw() & m_en & ~m_sel; endfunction
  function automatic logic [31:0] e_vec();
    logic [31:0] n = e_norm();
    for (int s = 0; s < NSL; s++) if (m_sen[s] && n[m_ssrc[s]]) return m_sadr[s];
    return m_dflt;
  endfunction
  function automatic logic [31:0] e_read(logic [5:0] a);
    case (a[5:4])
      2'd0: case (a[3:0])
        4'd0: return e_raw();
        4'd1: return e_fast();
        4'd2: return e_norm();
        4'd3: return m_sel;
        4'd4, 4'd5: return m_en;
        4'd6, 4'd7: return m_soft;
        4'd8: return e_vec();
        4'd9: return m_dflt;
        default: return '0;
      endcase
      2'd1: return {26'd0, m_sen[a[3:0]], m_ssrc[a[3:0]]};
      2'd2: return m_sadr[a[3:0]];
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sel = '0; m_en = '0; m_soft = '0; m_dflt = '0; m_sen = '0;
    for (int s = 0; s < NSL; s++) begin m_ssrc[s] = '0; m_sadr[s] = '0; end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
    if (a[5:4] == 2'd0) case (a[3:0])
      4'd3: m_sel = d;
      4'd4: m_en = m_en | d;
      4'd5: m_en = m_en & ~d;
      4'd6: m_soft = m_soft | d;
      4'd7: m_soft = m_soft & ~d;
      4'd9: m_dflt = d;
      default: ;
    endcase
    else if (a[5:4] == 2'd1) begin m_ssrc[a[3:0]] = d[4:0]; m_sen[a[3:0]] = d[5]; end
    else if (a[5:4] == 2'd2) m_sadr[a[3:0]] = d;
  endtask

  task automatic outs(string req);
    #1;
    chk({req, " fiq"}, {31'd0, fiq}, {31'd0, |e_fast()});
    chk({req, " irq"}, {31'd0, irq}, {31'd0, |e_norm()});
    chk({req, " vec"}, vec, e_vec());
  endtask

  task automatic rd(string req, logic [5:0] a);
    addr = a; #1;
    chk(req, rdata, e_read(a));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1c01));
    model_reset();
    repeat (3) @(negedge clk);
    src = 32'hffff_ffff;
    #1;
    // R9: reset state, sources active but nothing enabled
    chk("R9 fiq", {31'd0, fiq}, 32'd0);
    chk("R9 irq", {31'd0, irq}, 32'd0);
    chk("R9 vec", vec, 32'd0);
    rst_n = 1'b1;
    rd("R9 en", 6'h04); rd("R9 sel", 6'h03); rd("R9 slot ctl", 6'h10);
    rd("R1 raw", 6'h00);
    src = '0;

    // R3: write-0 leaves bits, set/clear independent
    wr(6'h04, 32'h0000_00f0); rd("R3 set", 6'h04);
    wr(6'h04, 32'h0000_0000); rd("R3 zero set", 6'h04);
    wr(6'h05, 32'h0000_0030); rd("R3 clr", 6'h05);
    wr(6'h05, 32'h0000_0000); rd("R3 zero clr", 6'h04);
    // R4
    wr(6'h06, 32'h0000_0081); rd("R4 set", 6'h06);
    wr(6'h07, 32'h0000_0001); rd("R4 clr", 6'h07);
    rd("R1 soft in raw", 6'h00);
    outs("R5 soft irq");

    // R7/R10/R8 directed priority
    wr(6'h09, 32'hdead_0000);
    wr(6'h04, 32'hffff_ffff);
    wr(6'h07, 32'hffff_ffff);
    wr(6'h20, 32'h1000_0000); wr(6'h10, 32'h0000_0005);   // slot0 disabled, src5
    wr(6'h21, 32'h1000_0001); wr(6'h11, 32'h0000_0025);   // slot1 enabled src5
    wr(6'h22, 32'h1000_0002); wr(6'h12, 32'h0000_0025);   // slot2 enabled src5
    wr(6'h23, 32'h1000_0003); wr(6'h13, 32'h0000_0027);   // slot3 enabled src7
    @(negedge clk); src = 32'h0000_0020; outs("R10 disabled slot skipped");
    chk("R7 lowest enabled", vec, 32'h1000_0001);
    wr(6'h10, 32'h0000_0025);
    outs("R7 slot0 wins"); chk("R7 slot0", vec, 32'h1000_0000);
    wr(6'h03, 32'h0000_0020);
    outs("R10 fast not vectored"); chk("R8 default", vec, 32'hdead_0000);
    chk("R2 fiq", {31'd0, fiq}, 32'd1);
    @(negedge clk); src = 32'h0000_00a0; outs("R7 src7 slot3");
    chk("R7 slot3", vec, 32'h1000_0003);
    rd("R6 ctl read", 6'h13); rd("R6 adr read", 6'h23);
    rd("R2 fast stat", 6'h01); rd("R2 norm stat", 6'h02); rd("R7 vec read", 6'h08);
    // R11 unused addresses
    wr(6'h0c, 32'hffff_ffff); wr(6'h30, 32'hffff_ffff); wr(6'h3f, 32'h1234_5678);
    rd("R11 unused misc", 6'h0c); rd("R11 unused rgn", 6'h30);
    outs("R11 no effect");
    rd("R11 en intact", 6'h04); rd("R11 dflt intact", 6'h09);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      logic [31:0] d = $urandom;
      logic [5:0] a;
      case (k)
        0: a = 6'h03;
        1: a = 6'h04;
        2: a = 6'h05;
        3: begin a = 6'h06; d = d & $urandom & $urandom; end
        4: a = 6'h07;
        5: a = 6'h09;
        6, 7: begin a = {2'd1, 4'($urandom_range(0, 15))}; d = d | 32'h20; end
        8: a = {2'd2, 4'($urandom_range(0, 15))};
        default: a = 6'($urandom);
      endcase
      if ($urandom_range(0, 3) != 0) wr(a, d);
      @(negedge clk); src = $urandom & $urandom & $urandom;
      outs("R5 R7 R8 random");
      rd("R1 R2 R6 random read", 6'($urandom));
    end

    // R9 again: reset mid-run clears state
    @(negedge clk); rst_n = 1'b0; model_reset(); src = 32'hffff_ffff;
    #1; outs("R9 reset again");
    @(negedge clk); rst_n = 1'b1; rd("R9 dflt", 6'h09);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule